// File: doc/BRIEF.md
# Thermal Alert Interrupt Controller

This block gathers four hardware warning lines and turns them into one interrupt request on a selectable legacy IRQ number. The lines are a temperature-sensor alert, a temperature-sensor over-temperature line, a memory-module event line and a battery-low line. Each input passes through a two-flop synchronizer. A rising edge on the alert, over-temperature or memory-event line sets a sticky pending bit. The battery-low line is used as a plain level and is never latched.

Software sees two byte-wide registers on a simple bus with a 1-bit address and combinational read data. The control register holds a global enable, a 3-bit IRQ selector and one enable bit per source. The status register shows the three sticky bits, and software clears them by writing ones. The output is a 16-bit vector indexed by legacy IRQ number. A serial-IRQ encoder downstream reads this vector.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00, the status register reads 0x00 and every bit of `irq_req` is low.
- R2: A write with `bus_addr`=0 stores all 8 bits of `bus_wdata` in the control register, and the stored value reads back unchanged from address 0.
- R3: A rising edge on `alert_in`, `therm_in` or `event_in` sets status bit 0, 1 or 2 respectively. The bit is set at the third clock edge that samples the new level and stays set while the input stays high. After it is cleared, a steady high input does not set it again.
- R4: A write with `bus_addr`=1 clears each status bit whose `bus_wdata` bit is 1. It leaves each status bit whose `bus_wdata` bit is 0 unchanged.
- R5: Status bits 7:3 always read as 0, and writing to them has no effect.
- R6: If a new source edge and a write-one-clear reach the same status bit in the same cycle, the bit ends up set.
- R7: The request appears only on the `irq_req` line that the selector in control bits 6:4 picks: 0→3, 1→4, 2→5, 3→10, 4→6, 5→7, 6→9, 7→11. Every other line stays low.
- R8: When control bit 7 (the global enable) is 0, every `irq_req` line is low, whatever the status and masks hold.
- R9: A pending status bit drives the request only while its enable bit is 1. Bit 0 enables alert, bit 1 over-temperature and bit 2 memory event.
- R10: The synchronized battery-low level drives the request while control bit 3 is 1. It has no status bit, and the request drops once the level falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| alert_in | input | 1 | Temperature-sensor alert line (asynchronous) |
| therm_in | input | 1 | Temperature-sensor over-temperature line (asynchronous) |
| event_in | input | 1 | Memory-module event line (asynchronous) |
| batt_low_in | input | 1 | Battery-low level (asynchronous) |
| irq_req | output | 16 | Request lines indexed by legacy IRQ number |

## Verification
A wrong status or control flop shows up on `bus_rdata` in the same cycle it is read. It also shows up on `irq_req` in the cycle after the faulty update, because the request is decoded combinationally from those flops. A wrong selector decode puts the request on an illegal or wrong line as soon as any source is enabled. A missed or early edge detect moves the status bit by a cycle. The bench compares against a per-clock reference model, so it catches this timing shift.

// File: rtl/thermal_irq_pkg.sv
// Shared constants and the selector-to-IRQ mapping for the thermal interrupt block.
// Assumes a byte-wide register bus and 16 legacy IRQ lines.
package thermal_irq_pkg;
    localparam int DATA_W      = 8;
    localparam int N_EDGE_SRC  = 3;
    localparam int N_SRC       = N_EDGE_SRC + 1;
    localparam int SEL_W       = 3;
    localparam int IRQ_LINES   = 16;
    localparam int SYNC_STAGES = 2;

    localparam int EN_BIT   = 7;
    localparam int SEL_LSB  = 4;
    localparam int BATT_BIT = 3;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Map the 3-bit selector onto the legacy IRQ number (not monotonic).
    function automatic int irq_number(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 3;
            3'd1:    return 4;
            3'd2:    return 5;
            3'd3:    return 10;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 9;
            default: return 11;
        endcase
    endfunction
endpackage

// File: rtl/tis_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module tis_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tis_status.sv
// Sticky pending bits with rising-edge set and write-one-to-clear.
// Assumes synchronized inputs; a set in the same cycle as a clear wins.
module tis_status #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] pend,
    output logic [WIDTH-1:0] rise
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic prev_q;
        logic pend_q;

        assign rise[g] = level[g] & ~prev_q;

        // Remember the previous level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= level[g];
        end

        // Set on an edge, else clear on a write of one.
        always_ff @(posedge clk) begin
            if (!rst_n)       pend_q <= 1'b0;
            else if (rise[g]) pend_q <= 1'b1;
            else if (clr[g])  pend_q <= 1'b0;
        end

        assign pend[g] = pend_q;
    end
endmodule

// File: rtl/tis_route.sv
// Combines masked sources under a global enable and steers the request to one IRQ line.
// Assumes IRQ_LINES covers every number the selector mapping can produce.
module tis_route
    import thermal_irq_pkg::*;
#(
    parameter int NSRC  = 3,
    parameter int LINES = 16
) (
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  mask,
    input  logic             batt,
    input  logic             batt_mask,
    output logic [LINES-1:0] lines
);
    logic req;
    int   target;

    // Form the single combined request.
    always_comb begin
        req    = enable & ((|(pend & mask)) | (batt & batt_mask));
        target = irq_number(sel);
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign lines[g] = req && (target == g);
    end
endmodule

// File: rtl/thermal_irq_ctrl.sv
// Thermal alert interrupt controller: control and status registers, sticky events,
// masking and IRQ steering. Assumes single-cycle writes and a combinational read path.
module thermal_irq_ctrl
    import thermal_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 alert_in,
    input  logic                 therm_in,
    input  logic                 event_in,
    input  logic                 batt_low_in,
    output logic [IRQ_LINES-1:0] irq_req
);
    logic [N_SRC-1:0]      src_sync;
    logic [DATA_W-1:0]     ctrl_q;
    logic [N_EDGE_SRC-1:0] status_q;
    logic [N_EDGE_SRC-1:0] rise_vec;
    logic [N_EDGE_SRC-1:0] clr_vec;

    tis_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({batt_low_in, event_in, therm_in, alert_in}),
        .q     (src_sync)
    );

    // Hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (bus_we && bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata;
    end

    // Decode the write-one-to-clear strobes.
    always_comb begin
        clr_vec = (bus_we && bus_addr == ADDR_STAT) ? bus_wdata[N_EDGE_SRC-1:0] : '0;
    end

    tis_status #(.WIDTH(N_EDGE_SRC)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .level (src_sync[N_EDGE_SRC-1:0]),
        .clr   (clr_vec),
        .pend  (status_q),
        .rise  (rise_vec)
    );

    tis_route #(.NSRC(N_EDGE_SRC), .LINES(IRQ_LINES)) u_route (
        .enable    (ctrl_q[EN_BIT]),
        .sel       (ctrl_q[SEL_LSB +: SEL_W]),
        .pend      (status_q),
        .mask      (ctrl_q[N_EDGE_SRC-1:0]),
        .batt      (src_sync[N_SRC-1]),
        .batt_mask (ctrl_q[BATT_BIT]),
        .lines     (irq_req)
    );

    // Select read data; reserved status bits return zero.
    always_comb begin
        if (bus_addr == ADDR_CTRL) bus_rdata = ctrl_q;
        else                       bus_rdata = {{(DATA_W-N_EDGE_SRC){1'b0}}, status_q};
    end
endmodule

// File: rtl/thermal_irq_chk.sv
// Property checker for thermal_irq_ctrl, attached with bind.
module thermal_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_addr,
    input logic        bus_we,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [7:0]  ctrl_q,
    input logic [2:0]  status_q,
    input logic [2:0]  rise_vec,
    input logic [3:0]  src_sync,
    input logic [15:0] irq_req
);
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req));

    a_r7_legal_line: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~16'h0EF8) == 16'h0);

    a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> irq_req == 16'h0);

    a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_addr) |=> ctrl_q == $past(bus_wdata));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr && bus_wdata[0] && !rise_vec[0]) |=> !status_q[0]);

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[0] && !(bus_we && bus_addr && bus_wdata[0])) |=> status_q[0]);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rise_vec[1] |=> status_q[1]);

    a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr |-> bus_rdata[7:3] == 5'b0);

    a_r10_batt_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && ctrl_q[3] && src_sync[3]) |-> irq_req != 16'h0);
endmodule

bind thermal_irq_ctrl thermal_irq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q),
    .rise_vec  (rise_vec),
    .src_sync  (src_sync),
    .irq_req   (irq_req)
);

// File: tb/test_thermal_irq_ctrl.sv
module test_thermal_irq_ctrl;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        alert_in = 1'b0, therm_in = 1'b0, event_in = 1'b0, batt_low_in = 1'b0;
    logic [15:0] irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    thermal_irq_ctrl i_thermal_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alert_in(alert_in),
        .therm_in(therm_in), .event_in(event_in), .batt_low_in(batt_low_in),
        .irq_req(irq_req)
    );

    // Reference model, behavioural
    int          irq_map [8] = '{3, 4, 5, 10, 6, 7, 9, 11};
    logic [3:0]  m1, m2, m3;
    logic [7:0]  m_ctrl;
    logic [2:0]  m_stat;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; m3 <= '0; m_ctrl <= '0; m_stat <= '0;
        end else begin
            m1 <= {batt_low_in, event_in, therm_in, alert_in};
            m2 <= m1;
            m3 <= m2;
            if (bus_we && !bus_addr) m_ctrl <= bus_wdata;
            m_stat <= (m_stat & ~((bus_we && bus_addr) ? bus_wdata[2:0] : 3'b000))
                      | (m2[2:0] & ~m3[2:0]);
        end
    end

    function automatic logic [15:0] exp_irq();
        logic req;
        req = m_ctrl[7] && ((|(m_stat & m_ctrl[2:0])) || (m2[3] && m_ctrl[3]));
        return req ? (16'h1 << irq_map[m_ctrl[6:4]]) : 16'h0;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk("R7", irq_req, exp_irq());
            if (bus_addr) chk("R4", {8'h00, bus_rdata}, {13'h0, m_stat});
            else          chk("R2", {8'h00, bus_rdata}, {8'h00, m_ctrl});
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        chk(tag, {8'h00, bus_rdata}, {8'h00, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_check(1'b0, 8'h00, "R1");
        rd_check(1'b1, 8'h00, "R1");
        chk("R1", irq_req, 16'h0);

        // R2 control read/write
        wr(1'b0, 8'hA5);
        rd_check(1'b0, 8'hA5, "R2");
        wr(1'b0, 8'h00);

        // R3 alert edge sets bit 0; R8 disabled keeps lines low
        @(negedge clk) alert_in = 1'b1;
        idle(4);
        rd_check(1'b1, 8'h01, "R3");
        chk("R8", irq_req, 16'h0);
        wr(1'b1, 8'h01);
        idle(3);
        rd_check(1'b1, 8'h00, "R3");
        alert_in = 1'b0;

        // R5 reserved bits, R4 write zero keeps bit
        @(negedge clk) therm_in = 1'b1;
        idle(4);
        wr(1'b1, 8'hF8);
        rd_check(1'b1, 8'h02, "R5");
        wr(1'b1, 8'h00);
        rd_check(1'b1, 8'h02, "R4");

        // R8 / R9 enable and masks
        wr(1'b0, 8'h02);
        idle(1);
        chk("R8", irq_req, 16'h0);
        wr(1'b0, 8'h82);
        idle(1);
        chk("R9", irq_req, 16'h0008);
        wr(1'b0, 8'h81);
        idle(1);
        chk("R9", irq_req, 16'h0);

        // R7 selector mapping
        for (int s = 0; s < 8; s++) begin
            wr(1'b0, 8'h82 | 8'(s << 4));
            idle(1);
            chk("R7", irq_req, 16'h1 << irq_map[s]);
        end
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h07);
        therm_in = 1'b0;
        idle(3);

        // R6 set beats clear on the same cycle
        @(negedge clk) event_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 1'b1; bus_we = 1'b1; bus_wdata = 8'h04;
        @(negedge clk);
        bus_we = 1'b0;
        rd_check(1'b1, 8'h04, "R6");
        wr(1'b1, 8'h07);
        event_in = 1'b0;
        rd_check(1'b1, 8'h00, "R4");

        // R10 battery-low level, no latch
        wr(1'b0, 8'h88);
        @(negedge clk) batt_low_in = 1'b1;
        idle(3);
        chk("R10", irq_req, 16'h0008);
        rd_check(1'b1, 8'h00, "R10");
        batt_low_in = 1'b0;
        idle(3);
        chk("R10", irq_req, 16'h0);

        idle(2);
        finish_run();
    end
endmodule